// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer on a simple register bus. A fixed power-of-two prescaler turns the bus clock into a slow tick. While the block is enabled, the first stage counts its preload value down on that tick. When the first stage runs out, it raises a pending-interrupt flag and, in watchdog mode, hands over to the second stage. When the second stage runs out, the block sets a sticky timeout flag. If rebooting is allowed, it also drives a system-reset pulse of fixed length. Software keeps the system alive by restarting both stages through a guarded write to the reload register.

The preload registers and the reload register are guarded by a two-byte key. The two key bytes must be written to the reload register back to back. The key opens exactly one protected write and then closes again. A lock bit pins the enable on until the power-on reset. The timeout flag is cleared only by a power-on reset or by a keyed software write, so it still shows the cause of a reset after the reset it caused.

The countdown engine has four states:
- RUN1: stage one is counting. On expiry it moves to RUN2 in watchdog mode, or reloads itself in free-running mode.
- RUN2: stage two is counting. On expiry it moves to FIRE when rebooting is allowed, and to DONE otherwise.
- FIRE: the reset pulse is being driven. After the pulse length it moves to DONE.
- DONE: the engine waits for a keep-alive.

A keep-alive moves the engine from any state except FIRE back to RUN1.

The key sequencer has three states:
- IDLE: the key byte 0x80 moves it to HALF.
- HALF: the key byte 0x86 moves it to OPEN. Any other write to a guarded register moves it back to IDLE.
- OPEN: any guarded write is accepted and moves it back to IDLE.

Top module: `wdog2_top`

## Requirements
- R1: After power-on reset, the outputs are as follows:
  - irq_out and sys_rst_out are low.
  - The control register (0x14) reads 0x4: function bit set, enable clear, lock clear.
  - The reload register (0x0C) reads 0.
  - The config register (0x10) reads 0.
  - The preloads (0x00, 0x04) read their reset parameters.
  - The count register (0x18) reads the stage-one reset preload.
- R2: Writing the byte 0x80 and then the byte 0x86 to the reload register (0x0C) opens the key. Exactly one following write to a guarded register (0x00, 0x04, 0x0C) is accepted. A second write is ignored until the key is given again.
- R3: A guarded write without an open key is ignored, including a keep-alive. A guarded write of any other value between the two key bytes aborts the sequence, so a later 0x86 alone does not open the key.
- R4: An accepted reload write with bit 4 set restarts stage one from its preload and clears the prescaler. Stage one expires after max(preload,1) ticks.
- R5: One tick is 2^PRESC_W clock cycles. Both counts are CNT_W bits wide.
- R6: Stage-one expiry sets bit 0 of the status register (0x08). That bit is cleared by writing 1 to it. Config bits [1:0] select the interrupt output:
  - 00: irq_out stays low.
  - 01 or 11: irq_out follows the status bit.
  - 10: irq_out gives a one-cycle pulse at each expiry.
- R7: In watchdog mode, stage two runs for max(preload2,1) ticks after stage one expires. On stage-two expiry the timeout flag (reload bit 9) is set. If config bit 5 is set, sys_rst_out is then high for exactly RST_CYC clock cycles; if bit 5 is clear, sys_rst_out stays low.
- R8: The timeout flag is cleared only by an accepted reload write with bit 9 set. Control-register writes and unkeyed reload writes leave it unchanged.
- R9: Control bit 0 (lock) can be set but not cleared by software. While lock is set, enable (bit 1) cannot be cleared and the function bit (bit 2) cannot change.
- R10: While enable is clear, the prescaler and the count hold their values.
- R11: With the function bit clear (free-running mode), stage one reloads itself at every expiry. Stage two never runs and no reset pulse is produced.
- R12: The count register (0x18) returns the live count of the running stage.
- R13: After a reset pulse the engine waits in DONE, and no further pulse occurs until a keep-alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Stage-one interrupt |
| sys_rst_out | output | 1 | Registered system-reset pulse |

## Verification
The bench sweeps both preloads over a small grid, including a zero preload, with a four-cycle tick. In each case it measures the exact cycle of the interrupt, the first cycle of the reset pulse and the pulse width. An off-by-one in the terminal-count compare, or a prescaler that is not cleared by the keep-alive, shifts these by whole ticks. The key tests cover three cases: an aborted sequence, a second write on one key, and an unkeyed keep-alive. A design that latched the key open would accept the second write, and one that restarted on any reload write would reset the count. The remaining tests target the hold, lock, free-running and flag-survival behaviour, where a wrong design would keep counting while disabled, let software unlock, pulse reset in free-running mode, or lose the flag on a control write.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_st_t;

    typedef enum logic [1:0] {
        WD_RUN1 = 2'd0,
        WD_RUN2 = 2'd1,
        WD_FIRE = 2'd2,
        WD_DONE = 2'd3
    } wd_st_t;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    localparam int OFF_PRE1   = 'h00;
    localparam int OFF_PRE2   = 'h04;
    localparam int OFF_STAT   = 'h08;
    localparam int OFF_RELOAD = 'h0C;
    localparam int OFF_CFG    = 'h10;
    localparam int OFF_CTRL   = 'h14;
    localparam int OFF_COUNT  = 'h18;

    localparam int BIT_KICK   = 4;
    localparam int BIT_TFLAG  = 9;
    localparam int BIT_REBOOT = 5;

    localparam logic [1:0] IRQ_NONE  = 2'b00;
    localparam logic [1:0] IRQ_PULSE = 2'b10;

endpackage

// File: rtl/wdog2_key.sv
module wdog2_key
    import wdog2_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_reload,
    input  logic       wr_guarded,
    input  logic [7:0] wbyte,
    output logic       key_open
);

    key_st_t st_q, st_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= KEY_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KEY_IDLE: if (wr_reload && wbyte == KEY_FIRST) st_d = KEY_HALF;
            KEY_HALF: begin
                if (wr_reload && wbyte == KEY_SECOND) st_d = KEY_OPEN;
                else if (wr_guarded)                   st_d = KEY_IDLE;
            end
            KEY_OPEN: if (wr_guarded) st_d = KEY_IDLE;
            default:  st_d = KEY_IDLE;
        endcase
    end

    always_comb begin
        key_open = (st_q == KEY_OPEN);
    end

endmodule

// File: rtl/wdog2_regs.sv
module wdog2_regs
    import wdog2_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 20,
    parameter logic [CNT_W-1:0] PRE1_RST = '1,
    parameter logic [CNT_W-1:0] PRE2_RST = '1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              key_open,
    input  logic              s1_expire,
    input  logic              fire_evt,
    input  logic [CNT_W-1:0]  cnt,
    output logic              wr_reload,
    output logic              wr_guarded,
    output logic              prot_acc,
    output logic              kick,
    output logic [CNT_W-1:0]  pre1,
    output logic [CNT_W-1:0]  pre2,
    output logic              en,
    output logic              lock,
    output logic              wdfunc,
    output logic              reboot_en,
    output logic              tflag,
    output logic              irq_out,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD = DATA_W - CNT_W;

    logic sel_pre1, sel_pre2, sel_stat, sel_rld, sel_cfg, sel_ctrl, sel_cnt;
    logic [1:0] irq_mode;
    logic       stat_q, stat_d, tflag_d, tflag_clr, irq_d;
    logic       unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CNT_W];

    assign sel_pre1 = (addr == ADDR_W'(OFF_PRE1));
    assign sel_pre2 = (addr == ADDR_W'(OFF_PRE2));
    assign sel_stat = (addr == ADDR_W'(OFF_STAT));
    assign sel_rld  = (addr == ADDR_W'(OFF_RELOAD));
    assign sel_cfg  = (addr == ADDR_W'(OFF_CFG));
    assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
    assign sel_cnt  = (addr == ADDR_W'(OFF_COUNT));

    assign wr_reload  = wr && sel_rld;
    assign wr_guarded = wr && (sel_pre1 || sel_pre2 || sel_rld);
    assign prot_acc   = key_open && wr_guarded;
    assign kick       = prot_acc && sel_rld && wdata[BIT_KICK];
    assign tflag_clr  = prot_acc && sel_rld && wdata[BIT_TFLAG];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre1 <= PRE1_RST;
            pre2 <= PRE2_RST;
        end else begin
            if (prot_acc && sel_pre1) pre1 <= wdata[CNT_W-1:0];
            if (prot_acc && sel_pre2) pre2 <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            irq_mode  <= IRQ_NONE;
            reboot_en <= 1'b0;
        end else if (wr && sel_cfg) begin
            irq_mode  <= wdata[1:0];
            reboot_en <= wdata[BIT_REBOOT];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock   <= 1'b0;
            en     <= 1'b0;
            wdfunc <= 1'b1;
        end else if (wr && sel_ctrl) begin
            lock   <= lock | wdata[0];
            en     <= wdata[1] | (lock & en);
            wdfunc <= lock ? wdfunc : wdata[2];
        end
    end

    always_comb begin
        stat_d  = s1_expire | (stat_q & ~(wr && sel_stat && wdata[0]));
        tflag_d = fire_evt | (tflag & ~tflag_clr);
        unique case (irq_mode)
            IRQ_NONE:  irq_d = 1'b0;
            IRQ_PULSE: irq_d = s1_expire;
            default:   irq_d = stat_d;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stat_q  <= 1'b0;
            tflag   <= 1'b0;
            irq_out <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            tflag   <= tflag_d;
            irq_out <= irq_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_pre1)      rdata = {{PAD{1'b0}}, pre1};
        else if (sel_pre2) rdata = {{PAD{1'b0}}, pre2};
        else if (sel_stat) rdata[0] = stat_q;
        else if (sel_rld)  rdata[BIT_TFLAG] = tflag;
        else if (sel_cfg)  rdata = DATA_W'({reboot_en, 3'b000, irq_mode});
        else if (sel_ctrl) rdata = DATA_W'({wdfunc, en, lock});
        else if (sel_cnt)  rdata = {{PAD{1'b0}}, cnt};
    end

endmodule

// File: rtl/wdog2_core.sv
module wdog2_core
    import wdog2_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int PRESC_W  = 15,
    parameter int RST_CYC  = 16,
    parameter logic [CNT_W-1:0] PRE1_RST = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic             wdfunc,
    input  logic             reboot_en,
    input  logic             kick,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic [CNT_W-1:0] cnt,
    output logic             s1_expire,
    output logic             fire_evt,
    output logic             rst_out
);

    localparam int RC_W = $clog2(RST_CYC + 1);
    localparam logic [RC_W-1:0]  RC_ONE  = RC_W'(1);
    localparam logic [RC_W-1:0]  RC_LAST = RC_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    wd_st_t            st_q, st_d;
    logic [CNT_W-1:0]  cnt_d;
    logic [RC_W-1:0]   rc_q, rc_d;
    logic              rst_d;
    logic              tick;
    logic              kick_acc;
    logic              at_end;

    assign kick_acc = kick && (st_q != WD_FIRE);
    assign at_end   = (cnt <= CNT_ONE);

    generate
        if (PRESC_W == 0) begin : g_nodiv
            assign tick = en;
        end else begin : g_div
            localparam logic [PRESC_W-1:0] P_ONE = PRESC_W'(1);
            logic [PRESC_W-1:0] pc_q;
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)        pc_q <= '0;
                else if (kick_acc) pc_q <= '0;
                else if (en)       pc_q <= pc_q + P_ONE;
            end
            assign tick = en && (&pc_q);
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q    <= WD_RUN1;
            cnt     <= PRE1_RST;
            rc_q    <= '0;
            rst_out <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt     <= cnt_d;
            rc_q    <= rc_d;
            rst_out <= rst_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt;
        rc_d  = rc_q;
        rst_d = rst_out;
        if (kick_acc) begin
            st_d  = WD_RUN1;
            cnt_d = pre1;
        end else begin
            unique case (st_q)
                WD_RUN1: begin
                    if (tick) begin
                        if (at_end) begin
                            if (wdfunc) begin
                                st_d  = WD_RUN2;
                                cnt_d = pre2;
                            end else begin
                                cnt_d = pre1;
                            end
                        end else begin
                            cnt_d = cnt - CNT_ONE;
                        end
                    end
                end
                WD_RUN2: begin
                    if (tick) begin
                        if (at_end) begin
                            cnt_d = '0;
                            if (reboot_en) begin
                                st_d  = WD_FIRE;
                                rst_d = 1'b1;
                                rc_d  = '0;
                            end else begin
                                st_d = WD_DONE;
                            end
                        end else begin
                            cnt_d = cnt - CNT_ONE;
                        end
                    end
                end
                WD_FIRE: begin
                    rc_d = rc_q + RC_ONE;
                    if (rc_q == RC_LAST) begin
                        rst_d = 1'b0;
                        st_d  = WD_DONE;
                    end
                end
                WD_DONE: ;
                default: st_d = WD_DONE;
            endcase
        end
    end

    always_comb begin
        s1_expire = !kick_acc && (st_q == WD_RUN1) && tick && at_end;
        fire_evt  = !kick_acc && (st_q == WD_RUN2) && tick && at_end;
    end

endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
    import wdog2_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 20,
    parameter int PRESC_W  = 15,
    parameter int RST_CYC  = 16,
    parameter logic [CNT_W-1:0] PRE1_RST = CNT_W'(30720),
    parameter logic [CNT_W-1:0] PRE2_RST = CNT_W'(30720)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              sys_rst_out
);

    logic             wr_reload, wr_guarded, prot_acc, kick, key_open;
    logic [CNT_W-1:0] pre1, pre2, cnt;
    logic             en, lock, wdfunc, reboot_en, tflag;
    logic             s1_expire, fire_evt;

    wdog2_key u_key (
        .clk        (clk),
        .por_n      (por_n),
        .wr_reload  (wr_reload),
        .wr_guarded (wr_guarded),
        .wbyte      (bus_wdata[7:0]),
        .key_open   (key_open)
    );

    wdog2_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .PRE1_RST (PRE1_RST),
        .PRE2_RST (PRE2_RST)
    ) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .key_open   (key_open),
        .s1_expire  (s1_expire),
        .fire_evt   (fire_evt),
        .cnt        (cnt),
        .wr_reload  (wr_reload),
        .wr_guarded (wr_guarded),
        .prot_acc   (prot_acc),
        .kick       (kick),
        .pre1       (pre1),
        .pre2       (pre2),
        .en         (en),
        .lock       (lock),
        .wdfunc     (wdfunc),
        .reboot_en  (reboot_en),
        .tflag      (tflag),
        .irq_out    (irq_out),
        .rdata      (bus_rdata)
    );

    wdog2_core #(
        .CNT_W    (CNT_W),
        .PRESC_W  (PRESC_W),
        .RST_CYC  (RST_CYC),
        .PRE1_RST (PRE1_RST)
    ) u_core (
        .clk       (clk),
        .por_n     (por_n),
        .en        (en),
        .wdfunc    (wdfunc),
        .reboot_en (reboot_en),
        .kick      (kick),
        .pre1      (pre1),
        .pre2      (pre2),
        .cnt       (cnt),
        .s1_expire (s1_expire),
        .fire_evt  (fire_evt),
        .rst_out   (sys_rst_out)
    );

endmodule

// File: rtl/wdog2_chk.sv
module wdog2_chk #(
    parameter int CNT_W   = 20,
    parameter int RST_CYC = 16
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_out,
    input logic             tflag,
    input logic             lock,
    input logic             en,
    input logic             kick,
    input logic             key_open,
    input logic             prot_acc,
    input logic             reboot_en,
    input logic [CNT_W-1:0] cnt
);

    localparam int HW = $clog2(RST_CYC + 2);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       hi_cnt <= '0;
        else if (rst_out) hi_cnt <= hi_cnt + HW'(1);
        else              hi_cnt <= '0;
    end

    AST_RST_MAX_LEN: assert property (@(posedge clk) disable iff (!por_n) rst_out |-> (hi_cnt < HW'(RST_CYC))); // R7
    AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!por_n) $fell(rst_out) |-> (hi_cnt == HW'(RST_CYC))); // R7
    AST_TFLAG_WITH_RST: assert property (@(posedge clk) disable iff (!por_n) $rose(rst_out) |-> tflag); // R7
    AST_REBOOT_GATE: assert property (@(posedge clk) disable iff (!por_n) $rose(rst_out) |-> $past(reboot_en)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n) lock |=> lock); // R9
    AST_EN_PINNED: assert property (@(posedge clk) disable iff (!por_n) (lock && en) |=> en); // R9
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!por_n) (!en && !kick) |=> $stable(cnt)); // R10
    AST_KEY_ONESHOT: assert property (@(posedge clk) disable iff (!por_n) prot_acc |=> !key_open); // R2

endmodule

bind wdog2_top wdog2_chk #(
    .CNT_W   (CNT_W),
    .RST_CYC (RST_CYC)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_out   (sys_rst_out),
    .tflag     (tflag),
    .lock      (lock),
    .en        (en),
    .kick      (kick),
    .key_open  (key_open),
    .prot_acc  (prot_acc),
    .reboot_en (reboot_en),
    .cnt       (cnt)
);

// File: tb/sim_wdog2_top.sv
`timescale 1ns/1ps
module sim_wdog2_top;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 20;
    localparam int PRESC_W = 2;
    localparam int TICK    = 1 << PRESC_W;
    localparam int RST_CYC = 16;
    localparam int P1R     = 1000;
    localparam int P2R     = 2000;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_out, sys_rst_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog2_top #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PRESC_W(PRESC_W),
        .RST_CYC(RST_CYC), .PRE1_RST(CNT_W'(P1R)), .PRE2_RST(CNT_W'(P2R))
    ) u0 (
        .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .sys_rst_out(sys_rst_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 v = int'(bus_rdata);
    endtask

    task automatic unlock();
        wr('h0C, 'h80);
        wr('h0C, 'h86);
    endtask

    task automatic kwr(input int a, input int d);
        unlock();
        wr(a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R13 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, c1, c2, c3, c4, n;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq", int'(irq_out), 0);
        chk("R1 rst", int'(sys_rst_out), 0);
        rd('h14, v); chk("R1 ctrl", v, 4);
        rd('h0C, v); chk("R1 reload", v, 0);
        rd('h10, v); chk("R1 cfg", v, 0);
        rd('h00, v); chk("R1 pre1", v, P1R);
        rd('h04, v); chk("R1 pre2", v, P2R);
        rd('h18, v); chk("R1 count", v, P1R);

        // R3 unkeyed and aborted writes
        wr('h00, 'h123);
        rd('h00, v); chk("R3 unkeyed pre1", v, P1R);
        wr('h0C, 'h80); wr('h0C, 'h55); wr('h0C, 'h86); wr('h00, 'h77);
        rd('h00, v); chk("R3 aborted key", v, P1R);
        // R2 one write per key
        unlock(); wr('h00, 5); wr('h00, 9);
        rd('h00, v); chk("R2 first write taken", v, 5);
        kwr('h04, 7);
        rd('h04, v); chk("R2 pre2 keyed", v, 7);

        wr('h14, 'h6);
        wr('h10, 'h21);

        // R4 R5 R6 R7 R13 sweep
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 3; j++) begin
                int p1, p2, e1, fi, fr, hi, win;
                p1 = (i == 4) ? 5 : i;
                p2 = 1 << j;
                e1 = (p1 < 1) ? 1 : p1;
                kwr('h00, p1);
                kwr('h04, p2);
                kwr('h0C, 'h200);
                wr('h08, 1);
                kwr('h0C, 'h10);
                fi = -1; fr = -1; hi = 0;
                win = TICK * (e1 + p2) + 40;
                for (int k = 1; k <= win; k++) begin
                    @(negedge clk);
                    #1;
                    if (irq_out && fi < 0) fi = k;
                    if (sys_rst_out) begin
                        hi++;
                        if (fr < 0) fr = k;
                    end
                end
                chk($sformatf("R4 R6 irq time p1=%0d", p1), fi, TICK * e1);
                chk($sformatf("R5 R7 rst time p1=%0d p2=%0d", p1, p2), fr, TICK * (e1 + p2));
                chk("R7 R13 rst width", hi, RST_CYC);
                rd('h0C, v); chk("R7 tflag set", (v >> 9) & 1, 1);
            end
        end

        // R12 live count
        kwr('h00, 50);
        kwr('h0C, 'h10);
        bus_addr = 8'h18;
        #1 chk("R12 count k=0", int'(bus_rdata), 50);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            #1 chk($sformatf("R12 count k=%0d", k), int'(bus_rdata), 50 - k / TICK);
        end
        // R10 hold when disabled, R3 unkeyed kick
        wr('h14, 'h4);
        rd('h18, c1);
        repeat (40) @(negedge clk);
        rd('h18, c2);
        chk("R10 hold", c2, c1);
        wr('h0C, 'h10);
        rd('h18, c3);
        chk("R3 unkeyed kick ignored", c3, c2);
        wr('h14, 'h6);
        repeat (20) @(negedge clk);
        rd('h18, c4);
        chk("R10 resumes", int'(c4 < c3), 1);

        // R8 timeout flag survival
        wr('h14, 'h4);
        rd('h0C, v); chk("R8 flag before", (v >> 9) & 1, 1);
        wr('h14, 'h4);
        rd('h0C, v); chk("R8 ctrl write keeps flag", (v >> 9) & 1, 1);
        wr('h0C, 'h200);
        rd('h0C, v); chk("R8 unkeyed clear ignored", (v >> 9) & 1, 1);
        kwr('h0C, 'h200);
        rd('h0C, v); chk("R8 keyed clear", (v >> 9) & 1, 0);

        // R6 mode none
        wr('h14, 'h6);
        wr('h10, 'h20);
        kwr('h00, 2);
        wr('h08, 1);
        kwr('h0C, 'h10);
        n = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            #1 if (irq_out) n++;
        end
        chk("R6 none irq", n, 0);
        rd('h08, v); chk("R6 status set", v & 1, 1);
        wr('h08, 1);
        rd('h08, v); chk("R6 status w1c", v & 1, 0);
        // R6 pulse mode
        wr('h10, 'h22);
        kwr('h0C, 'h10);
        n = 0; c1 = -1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            #1 if (irq_out) begin n++; c1 = k; end
        end
        chk("R6 pulse count", n, 1);
        chk("R6 pulse time", c1, 2 * TICK);

        // R7 reboot disabled
        repeat (40) @(negedge clk);
        kwr('h0C, 'h200);
        wr('h10, 'h01);
        kwr('h0C, 'h10);
        n = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            #1 if (sys_rst_out) n++;
        end
        chk("R7 no rst when reboot off", n, 0);
        rd('h0C, v); chk("R7 flag without rst", (v >> 9) & 1, 1);

        // R11 free-running
        wr('h14, 'h2);
        wr('h10, 'h22);
        kwr('h00, 3);
        kwr('h0C, 'h10);
        n = 0; c1 = 0;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            #1;
            if (irq_out) n++;
            if (sys_rst_out) c1++;
        end
        chk("R11 periodic expiries", n, 100 / (3 * TICK));
        chk("R11 no rst", c1, 0);

        // R9 lock
        wr('h14, 'h7);
        rd('h14, v); chk("R9 locked", v, 7);
        wr('h14, 'h0);
        rd('h14, v); chk("R9 cannot unlock", v, 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule